// File: doc/BRIEF.md
# Miss Status Holding Register File

This block tracks the outstanding misses of a non-blocking data cache, so the cache can keep serving hits while earlier misses wait for memory. It holds a small pool of entries. On a primary miss it takes the lowest-numbered free entry. That entry stores the block address, the cache index the returning line will be written to, and, for the missing word, either the destination register tag of a load or the data of a store. The entry number travels with the memory request as its tag.

A later miss to a block that is already pending is merged into the existing entry instead of opening a duplicate. Memory may answer in any order. When a response arrives tagged with a busy entry, the block performs three actions in the same cycle:
- it emits the cache fill, with pending store words overlaid on the returned line;
- it forwards the matching word to every recorded load register;
- it releases the entry.

When a miss cannot be accepted, `stall_o` tells the pipeline to hold the request and present it again.

Top module: `mshr_file`

## Requirements
- R1: Out of reset every entry is free: a response produces no fill and no forward, and the first miss is given entry 0.
- R2: A miss to a block with no busy entry, while an entry is free, takes the lowest-numbered free entry. In the same cycle `mem_req_valid_o` is 1, `mem_req_blk_o` is the block address and `mem_req_id_o` is that entry number.
- R3: A miss to a block that already has a busy entry issues no memory request and is recorded in that entry, so no two busy entries ever hold the same block.
- R4: A miss to a non-pending block while all entries are busy raises `stall_o`, issues no request and changes no entry.
- R5: A load miss merging into an entry whose slot for the same word already holds a register tag raises `stall_o`; the earlier tag is kept.
- R6: A response whose `rsp_id_i` names a busy entry raises `fill_valid_o` in the same cycle, with `fill_idx_o` equal to the index stored for that entry, and frees the entry at the clock edge.
- R7: During a fill, `fwd_valid_o[w]` is 1 for each word w that holds a load tag. `fwd_reg_o[w*REG_W +: REG_W]` carries that tag, and the word to forward is `fill_data_o[w*WORD_W +: WORD_W]`.
- R8: A store miss never stalls on a slot and marks its word as written, a later store to the same word replacing the data. On fill, written words of `fill_data_o` take the stored data and the other words take `rsp_data_i[w*WORD_W +: WORD_W]`.
- R9: Responses may arrive in any order; each fill uses only the information of the entry it names.
- R10: A response naming a free entry is ignored: no fill, no forward, no state change.
- R11: A miss to the block of the entry being filled in that same cycle raises `stall_o` and is not merged.
- R12: An entry freed by a response cannot be allocated in the same cycle; it is available from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| miss_valid_i | input | 1 | A cache miss is presented |
| miss_we_i | input | 1 | 1 = store miss, 0 = load miss |
| miss_blk_i | input | BLK_W | Block address of the miss |
| miss_idx_i | input | IDX_W | Cache index the block fills |
| miss_word_i | input | WOFF_W | Word offset within the block |
| miss_reg_i | input | REG_W | Destination register tag (loads) |
| miss_wdata_i | input | WORD_W | Store data (stores) |
| stall_o | output | 1 | Miss not accepted this cycle |
| mem_req_valid_o | output | 1 | New memory request issued |
| mem_req_blk_o | output | BLK_W | Block address requested |
| mem_req_id_o | output | ID_W | Entry tag of the request |
| rsp_valid_i | input | 1 | Memory response present |
| rsp_id_i | input | ID_W | Entry tag of the response |
| rsp_data_i | input | WORDS*WORD_W | Returned block, word w at w*WORD_W |
| fill_valid_o | output | 1 | Cache line fill this cycle |
| fill_idx_o | output | IDX_W | Cache index to write |
| fill_data_o | output | WORDS*WORD_W | Line to write, stores merged |
| fwd_valid_o | output | WORDS | Per-word forward strobe |
| fwd_reg_o | output | WORDS*REG_W | Per-word destination register tag |

## Verification
The bench builds the block with four entries and four words per block, with narrow block, index, register and data fields. With only four entries, full-pool stalls happen within a few misses. Drawing addresses from a pool of eight blocks makes merges, word-slot conflicts, fill collisions and same-cycle reuse of a freed entry common in the random phase. Four words per block leave room for loads and stores to share a line on different words while other words are returned untouched.

// File: rtl/mshr_pkg.sv
package mshr_pkg;
  typedef enum logic [1:0] {
    ACT_IDLE  = 2'd0,
    ACT_ALLOC = 2'd1,
    ACT_MERGE = 2'd2,
    ACT_CLEAR = 2'd3
  } ent_act_e;
endpackage

// File: rtl/mshr_prio.sv
module mshr_prio #(
  parameter int N    = 4,
  parameter int ID_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]    req_i,
  output logic            any_o,
  output logic [ID_W-1:0] id_o
);
  // lowest set bit wins
  always_comb begin
    id_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) id_o = ID_W'(i);
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/mshr_entry.sv
module mshr_entry
  import mshr_pkg::*;
#(
  parameter int BLK_W  = 26,
  parameter int IDX_W  = 8,
  parameter int WORDS  = 4,
  parameter int REG_W  = 6,
  parameter int WORD_W = 32,
  localparam int WOFF_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  ent_act_e                          act_i,
  input  logic [BLK_W-1:0]                  blk_i,
  input  logic [IDX_W-1:0]                  idx_i,
  input  logic [WOFF_W-1:0]                 word_i,
  input  logic [REG_W-1:0]                  reg_i,
  input  logic                              we_i,
  input  logic [WORD_W-1:0]                 wdata_i,
  output logic                              valid_o,
  output logic                              match_o,
  output logic                              slot_busy_o,
  output logic [IDX_W-1:0]                  idx_o,
  output logic [WORDS-1:0]                  reg_vld_o,
  output logic [WORDS-1:0][REG_W-1:0]       regs_o,
  output logic [WORDS-1:0]                  st_vld_o,
  output logic [WORDS-1:0][WORD_W-1:0]      st_data_o
);
  logic                         valid_q;
  logic [BLK_W-1:0]             blk_q;
  logic [IDX_W-1:0]             idx_q;
  logic [WORDS-1:0]             reg_vld_q;
  logic [WORDS-1:0][REG_W-1:0]  regs_q;
  logic [WORDS-1:0]             st_vld_q;
  logic [WORDS-1:0][WORD_W-1:0] st_data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q   <= 1'b0;
      blk_q     <= '0;
      idx_q     <= '0;
      reg_vld_q <= '0;
      regs_q    <= '0;
      st_vld_q  <= '0;
      st_data_q <= '0;
    end else begin
      unique case (act_i)
        ACT_ALLOC: begin
          valid_q <= 1'b1;
          blk_q   <= blk_i;
          idx_q   <= idx_i;
          for (int w = 0; w < WORDS; w++) begin
            reg_vld_q[w] <= !we_i && (word_i == WOFF_W'(w));
            st_vld_q[w]  <= we_i && (word_i == WOFF_W'(w));
            if (word_i == WOFF_W'(w)) begin
              regs_q[w]    <= reg_i;
              st_data_q[w] <= wdata_i;
            end
          end
        end
        ACT_MERGE: begin
          for (int w = 0; w < WORDS; w++) begin
            if (word_i == WOFF_W'(w)) begin
              if (we_i) begin
                st_vld_q[w]  <= 1'b1;
                st_data_q[w] <= wdata_i;
              end else begin
                reg_vld_q[w] <= 1'b1;
                regs_q[w]    <= reg_i;
              end
            end
          end
        end
        ACT_CLEAR: begin
          valid_q   <= 1'b0;
          reg_vld_q <= '0;
          st_vld_q  <= '0;
        end
        default: ;
      endcase
    end
  end

  assign valid_o     = valid_q;
  assign match_o     = valid_q && (blk_q == blk_i);
  assign slot_busy_o = reg_vld_q[word_i];
  assign idx_o       = idx_q;
  assign reg_vld_o   = reg_vld_q;
  assign regs_o      = regs_q;
  assign st_vld_o    = st_vld_q;
  assign st_data_o   = st_data_q;

  assert_alloc_free_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i == ACT_ALLOC |-> !valid_q);
  assert_merge_hit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i == ACT_MERGE |-> valid_q && match_o);
  assert_slot_free_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i == ACT_MERGE && !we_i) |-> !reg_vld_q[word_i]);
  assert_clear_frees_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i == ACT_CLEAR |=> !valid_q && reg_vld_q == '0 && st_vld_q == '0);
endmodule

// File: rtl/mshr_fill.sv
module mshr_fill #(
  parameter int N      = 4,
  parameter int IDX_W  = 8,
  parameter int WORDS  = 4,
  parameter int REG_W  = 6,
  parameter int WORD_W = 32,
  localparam int ID_W  = (N > 1) ? $clog2(N) : 1
) (
  input  logic                                  rsp_valid_i,
  input  logic [ID_W-1:0]                       rsp_id_i,
  input  logic [WORDS-1:0][WORD_W-1:0]          rsp_data_i,
  input  logic [N-1:0]                          valid_vec_i,
  input  logic [N-1:0][IDX_W-1:0]               idx_all_i,
  input  logic [N-1:0][WORDS-1:0]               rv_all_i,
  input  logic [N-1:0][WORDS-1:0][REG_W-1:0]    regs_all_i,
  input  logic [N-1:0][WORDS-1:0]               sv_all_i,
  input  logic [N-1:0][WORDS-1:0][WORD_W-1:0]   sd_all_i,
  output logic [N-1:0]                          rsp_sel_o,
  output logic                                  fill_valid_o,
  output logic [IDX_W-1:0]                      fill_idx_o,
  output logic [WORDS-1:0][WORD_W-1:0]          fill_data_o,
  output logic [WORDS-1:0]                      fwd_valid_o,
  output logic [WORDS-1:0][REG_W-1:0]           fwd_reg_o
);
  logic [IDX_W-1:0]             idx_s;
  logic [WORDS-1:0]             rv_s, sv_s;
  logic [WORDS-1:0][REG_W-1:0]  regs_s;
  logic [WORDS-1:0][WORD_W-1:0] sd_s;

  // entry select by tag; free entries never match
  always_comb begin
    idx_s  = '0;
    rv_s   = '0;
    sv_s   = '0;
    regs_s = '0;
    sd_s   = '0;
    for (int i = 0; i < N; i++) begin
      rsp_sel_o[i] = rsp_valid_i && valid_vec_i[i] && (rsp_id_i == ID_W'(i));
      if (rsp_sel_o[i]) begin
        idx_s  = idx_all_i[i];
        rv_s   = rv_all_i[i];
        sv_s   = sv_all_i[i];
        regs_s = regs_all_i[i];
        sd_s   = sd_all_i[i];
      end
    end
  end

  assign fill_valid_o = |rsp_sel_o;
  assign fill_idx_o   = idx_s;

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    assign fill_data_o[w] = sv_s[w] ? sd_s[w] : rsp_data_i[w];
    assign fwd_valid_o[w] = fill_valid_o && rv_s[w];
    assign fwd_reg_o[w]   = regs_s[w];
  end
endmodule

// File: rtl/mshr_file.sv
module mshr_file
  import mshr_pkg::*;
#(
  parameter int N      = 4,
  parameter int BLK_W  = 26,
  parameter int IDX_W  = 8,
  parameter int WORDS  = 4,
  parameter int REG_W  = 6,
  parameter int WORD_W = 32,
  localparam int ID_W   = (N > 1) ? $clog2(N) : 1,
  localparam int WOFF_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    miss_valid_i,
  input  logic                    miss_we_i,
  input  logic [BLK_W-1:0]        miss_blk_i,
  input  logic [IDX_W-1:0]        miss_idx_i,
  input  logic [WOFF_W-1:0]       miss_word_i,
  input  logic [REG_W-1:0]        miss_reg_i,
  input  logic [WORD_W-1:0]       miss_wdata_i,
  output logic                    stall_o,
  output logic                    mem_req_valid_o,
  output logic [BLK_W-1:0]        mem_req_blk_o,
  output logic [ID_W-1:0]         mem_req_id_o,
  input  logic                    rsp_valid_i,
  input  logic [ID_W-1:0]         rsp_id_i,
  input  logic [WORDS*WORD_W-1:0] rsp_data_i,
  output logic                    fill_valid_o,
  output logic [IDX_W-1:0]        fill_idx_o,
  output logic [WORDS*WORD_W-1:0] fill_data_o,
  output logic [WORDS-1:0]        fwd_valid_o,
  output logic [WORDS*REG_W-1:0]  fwd_reg_o
);
  logic [N-1:0]                        valid_vec, match_vec, slot_vec, rsp_sel;
  logic [N-1:0][IDX_W-1:0]             idx_all;
  logic [N-1:0][WORDS-1:0]             rv_all, sv_all;
  logic [N-1:0][WORDS-1:0][REG_W-1:0]  regs_all;
  logic [N-1:0][WORDS-1:0][WORD_W-1:0] sd_all;
  ent_act_e                            act [N];

  logic            any_free, any_match;
  logic [ID_W-1:0] free_id, match_id;
  logic            collide, slot_taken, accept, do_alloc, do_merge;

  mshr_prio #(.N(N)) u_free_pick (
    .req_i (~valid_vec),
    .any_o (any_free),
    .id_o  (free_id)
  );

  mshr_prio #(.N(N)) u_match_enc (
    .req_i (match_vec),
    .any_o (any_match),
    .id_o  (match_id)
  );

  assign collide    = |(match_vec & rsp_sel);
  assign slot_taken = |(match_vec & slot_vec);
  assign accept     = any_match ? (!collide && (miss_we_i || !slot_taken)) : any_free;
  assign do_alloc   = miss_valid_i && !any_match && any_free;
  assign do_merge   = miss_valid_i && any_match && accept;

  assign stall_o         = miss_valid_i && !accept;
  assign mem_req_valid_o = do_alloc;
  assign mem_req_blk_o   = miss_blk_i;
  assign mem_req_id_o    = free_id;

  for (genvar i = 0; i < N; i++) begin : g_ent
    always_comb begin
      if (rsp_sel[i])                                act[i] = ACT_CLEAR;
      else if (do_alloc && free_id == ID_W'(i))      act[i] = ACT_ALLOC;
      else if (do_merge && match_vec[i])             act[i] = ACT_MERGE;
      else                                           act[i] = ACT_IDLE;
    end

    mshr_entry #(
      .BLK_W(BLK_W), .IDX_W(IDX_W), .WORDS(WORDS), .REG_W(REG_W), .WORD_W(WORD_W)
    ) u_ent (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .act_i       (act[i]),
      .blk_i       (miss_blk_i),
      .idx_i       (miss_idx_i),
      .word_i      (miss_word_i),
      .reg_i       (miss_reg_i),
      .we_i        (miss_we_i),
      .wdata_i     (miss_wdata_i),
      .valid_o     (valid_vec[i]),
      .match_o     (match_vec[i]),
      .slot_busy_o (slot_vec[i]),
      .idx_o       (idx_all[i]),
      .reg_vld_o   (rv_all[i]),
      .regs_o      (regs_all[i]),
      .st_vld_o    (sv_all[i]),
      .st_data_o   (sd_all[i])
    );
  end

  mshr_fill #(
    .N(N), .IDX_W(IDX_W), .WORDS(WORDS), .REG_W(REG_W), .WORD_W(WORD_W)
  ) u_fill (
    .rsp_valid_i  (rsp_valid_i),
    .rsp_id_i     (rsp_id_i),
    .rsp_data_i   (rsp_data_i),
    .valid_vec_i  (valid_vec),
    .idx_all_i    (idx_all),
    .rv_all_i     (rv_all),
    .regs_all_i   (regs_all),
    .sv_all_i     (sv_all),
    .sd_all_i     (sd_all),
    .rsp_sel_o    (rsp_sel),
    .fill_valid_o (fill_valid_o),
    .fill_idx_o   (fill_idx_o),
    .fill_data_o  (fill_data_o),
    .fwd_valid_o  (fwd_valid_o),
    .fwd_reg_o    (fwd_reg_o)
  );

  assert_no_dup_block_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match_vec));
  assert_stall_no_req_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> !mem_req_valid_o);
  assert_fill_frees_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_valid_o |=> $countones(valid_vec) <= $countones($past(valid_vec)));
  assert_fwd_in_fill_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_valid_o != '0) |-> fill_valid_o);
  assert_no_same_cycle_reuse_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_o && mem_req_valid_o) |-> mem_req_id_o != rsp_id_i);
  assert_collide_stalls_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_valid_i && collide) |-> stall_o && !mem_req_valid_o);
endmodule

// File: tb/mshr_file_tb.sv
`timescale 1ns/1ps
module mshr_file_tb;
  localparam int N = 4, BW = 10, IW = 6, W = 4, RW = 5, DW = 16, IDW = 2, WOW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mv = 0, mwe = 0, rv = 0;
  logic [BW-1:0] mblk = '0;
  logic [IW-1:0] midx = '0;
  logic [WOW-1:0] mword = '0;
  logic [RW-1:0] mreg = '0;
  logic [DW-1:0] mwd = '0;
  logic [IDW-1:0] rid = '0;
  logic [W*DW-1:0] rdat = '0;
  logic stall, req_v, fill_v;
  logic [BW-1:0] req_blk;
  logic [IDW-1:0] req_id;
  logic [IW-1:0] fill_idx;
  logic [W*DW-1:0] fill_dat;
  logic [W-1:0] fwd_v;
  logic [W*RW-1:0] fwd_reg;

  always #4 clk = ~clk;

  mshr_file #(.N(N), .BLK_W(BW), .IDX_W(IW), .WORDS(W), .REG_W(RW), .WORD_W(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .miss_valid_i(mv), .miss_we_i(mwe), .miss_blk_i(mblk), .miss_idx_i(midx),
    .miss_word_i(mword), .miss_reg_i(mreg), .miss_wdata_i(mwd),
    .stall_o(stall), .mem_req_valid_o(req_v), .mem_req_blk_o(req_blk), .mem_req_id_o(req_id),
    .rsp_valid_i(rv), .rsp_id_i(rid), .rsp_data_i(rdat),
    .fill_valid_o(fill_v), .fill_idx_o(fill_idx), .fill_data_o(fill_dat),
    .fwd_valid_o(fwd_v), .fwd_reg_o(fwd_reg)
  );

  int n_chk = 0, n_bad = 0;
  bit            m_v  [N];
  logic [BW-1:0] m_b  [N];
  logic [IW-1:0] m_i  [N];
  bit            m_rv [N][W];
  logic [RW-1:0] m_r  [N][W];
  bit            m_sv [N][W];
  logic [DW-1:0] m_sd [N][W];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic mark(input int e, input bit we, input logic [WOW-1:0] wd,
                      input logic [RW-1:0] r, input logic [DW-1:0] d);
    if (we) begin m_sv[e][wd] = 1; m_sd[e][wd] = d; end
    else    begin m_rv[e][wd] = 1; m_r[e][wd]  = r; end
  endtask

  task automatic cyc(input bit imv, input bit iwe, input logic [BW-1:0] b, input logic [IW-1:0] ix,
                     input logic [WOW-1:0] wd, input logic [RW-1:0] r, input logic [DW-1:0] d,
                     input bit irv, input logic [IDW-1:0] id, input logic [W*DW-1:0] rd);
    int match, free;
    bit rhit, acc, e_stall, e_req;
    logic [W*DW-1:0] e_dat;
    logic [W-1:0] e_fv;
    @(negedge clk);
    mv = imv; mwe = iwe; mblk = b; midx = ix; mword = wd; mreg = r; mwd = d;
    rv = irv; rid = id; rdat = rd;
    #1;
    match = -1; free = -1;
    for (int i = 0; i < N; i++) if (m_v[i] && m_b[i] == b) match = i;
    for (int i = N - 1; i >= 0; i--) if (!m_v[i]) free = i;
    rhit = irv && m_v[id];
    if (match >= 0) acc = !(rhit && id == match) && (iwe || !m_rv[match][wd]);
    else            acc = (free >= 0);
    e_stall = imv && !acc;
    e_req   = imv && match < 0 && free >= 0;
    chk("R4/R5/R11 stall", stall, e_stall);
    chk("R2/R3 mem_req_valid", req_v, e_req);
    if (e_req) begin
      chk("R2 mem_req_id", req_id, free);
      chk("R2 mem_req_blk", req_blk, b);
    end
    chk("R6/R10 fill_valid", fill_v, rhit);
    if (rhit) begin
      for (int w = 0; w < W; w++) begin
        e_dat[w*DW +: DW] = m_sv[id][w] ? m_sd[id][w] : rd[w*DW +: DW];
        e_fv[w] = m_rv[id][w];
      end
      chk("R6/R9 fill_idx", fill_idx, m_i[id]);
      chk("R8 fill_data", fill_dat, e_dat);
      chk("R7 fwd_valid", fwd_v, e_fv);
      for (int w = 0; w < W; w++)
        if (m_rv[id][w]) chk("R7 fwd_reg", fwd_reg[w*RW +: RW], m_r[id][w]);
    end else begin
      chk("R10 fwd_valid idle", fwd_v, '0);
    end
    @(posedge clk);
    if (rhit) begin
      m_v[id] = 0;
      for (int w = 0; w < W; w++) begin m_rv[id][w] = 0; m_sv[id][w] = 0; end
    end
    if (e_req) begin
      m_v[free] = 1; m_b[free] = b; m_i[free] = ix;
      for (int w = 0; w < W; w++) begin m_rv[free][w] = 0; m_sv[free][w] = 0; end
      mark(free, iwe, wd, r, d);
    end else if (imv && match >= 0 && acc) begin
      mark(match, iwe, wd, r, d);
    end
  endtask

  function automatic logic [W*DW-1:0] rnd_line();
    return {$urandom, $urandom};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    for (int i = 0; i < N; i++) begin
      m_v[i] = 0;
      for (int w = 0; w < W; w++) begin m_rv[i][w] = 0; m_sv[i][w] = 0; end
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: idle after reset, response to a free id does nothing
    rv = 1; rid = 2'd1; rdat = 64'h1234;
    #1;
    chk("R1 fill_valid after reset", fill_v, 0);
    chk("R1 fwd_valid after reset", fwd_v, '0);
    chk("R1 stall after reset", stall, 0);
    chk("R1 mem_req after reset", req_v, 0);
    rv = 0;
    // R1/R2: first miss gets entry 0, then 1..3
    cyc(1, 0, 10'd1, 6'd11, 2'd0, 5'd3, '0, 0, '0, '0);
    cyc(1, 0, 10'd2, 6'd12, 2'd0, 5'd4, '0, 0, '0, '0);
    cyc(1, 0, 10'd3, 6'd13, 2'd2, 5'd5, '0, 0, '0, '0);
    cyc(1, 1, 10'd4, 6'd14, 2'd1, '0, 16'hAAAA, 0, '0, '0);
    // R4: full
    cyc(1, 0, 10'd5, 6'd15, 2'd0, 5'd6, '0, 0, '0, '0);
    // R3 merge, R5 slot conflict, R8 stores
    cyc(1, 0, 10'd2, 6'd12, 2'd1, 5'd7, '0, 0, '0, '0);
    cyc(1, 0, 10'd2, 6'd12, 2'd1, 5'd9, '0, 0, '0, '0);
    cyc(1, 1, 10'd2, 6'd12, 2'd1, '0, 16'hBEEF, 0, '0, '0);
    cyc(1, 1, 10'd2, 6'd12, 2'd3, '0, 16'h1111, 0, '0, '0);
    cyc(1, 1, 10'd2, 6'd12, 2'd3, '0, 16'h2222, 0, '0, '0);
    // R9 out of order, R12 no same-cycle reuse
    cyc(1, 0, 10'd6, 6'd16, 2'd0, 5'd8, '0, 1, 2'd2, 64'h0123_4567_89AB_CDEF);
    cyc(1, 0, 10'd6, 6'd16, 2'd0, 5'd8, '0, 0, '0, '0);
    // R11 collision with fill of block 2, R8 merged store words
    cyc(1, 0, 10'd2, 6'd12, 2'd2, 5'd10, '0, 1, 2'd1, 64'hFEDC_BA98_7654_3210);
    // R10 response to freed id
    cyc(0, 0, '0, '0, '0, '0, '0, 1, 2'd1, 64'h5555_5555_5555_5555);
    cyc(0, 0, '0, '0, '0, '0, '0, 1, 2'd0, rnd_line());
    cyc(0, 0, '0, '0, '0, '0, '0, 1, 2'd3, rnd_line());
    cyc(0, 0, '0, '0, '0, '0, '0, 1, 2'd2, rnd_line());
    // random mix over a small block pool
    for (int k = 0; k < 4000; k++) begin
      cyc(($urandom % 10) < 6, ($urandom % 4) == 0, BW'($urandom % 8), IW'($urandom),
          WOW'($urandom), RW'($urandom), DW'($urandom),
          ($urandom % 10) < 4, IDW'($urandom), rnd_line());
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule